// File: doc/BRIEF.md
# Skew Delay-Code Serial Register Target

This block is the serial control port of a three-channel video skew corrector. A host uses a four-wire SPI link (active-low chip select, clock, data in, data out) to set and read three 6-bit delay codes, one per colour channel. The codes go straight to the analog delay-line block. The SPI wires are assumed to be already synchronised into the system clock domain, and the block finds SCK rising edges by sampling.

Every transfer is a fixed 16-bit frame, sent MSB first. The first byte is the command. Its bit 7 is the direction (0 means write, 1 means read) and its bits 1:0 select the channel. The second byte carries the code in bits 5:0. On a read, the stored code is shifted back on SDO while the second byte is clocked. A separate enable input gates the whole port, so it responds only when digital control through SPI has been chosen.

Top module: `skew_code_spi`

## Requirements
- R1: After reset, all three codes are 0 and SDO is 0.
- R2: A 16-bit frame with command bit 7 = 0 writes data bits 5:0 to the channel chosen by command bits 1:0 (00 red, 01 green, 10 blue). SDI is sampled on each SCK rise, MSB first. The code output changes within two system clocks of the 16th rise.
- R3: Bits 7:6 of the data byte have no effect on a written code.
- R4: With command bit 7 = 1, SDO shows the data byte {2'b00, code} MSB first. Its bit 7 appears after the 8th SCK rise and its bit 0 after the 15th. The read leaves every code unchanged.
- R5: Channel select 11 writes nothing, and a read of it returns 0.
- R6: If CS rises before 16 rises, the frame is discarded: no code changes, and the next frame starts again at bit 0.
- R7: SCK rises after the 16th in the same CS-low period are ignored.
- R8: While the enable input is low, SCK activity changes no code and SDO stays 0.
- R9: SDO is 0 during the command byte, throughout write frames, and after the 16th rise.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiEnable | input | 1 | High when digital SPI control is selected |
| csN | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock |
| sdi | input | 1 | Synchronised serial data in |
| sdo | output | 1 | Serial data out |
| codeRed | output | 6 | Red channel delay code |
| codeGreen | output | 6 | Green channel delay code |
| codeBlue | output | 6 | Blue channel delay code |

## Verification
The hardest situation to reach from the ports is a frame that breaks at an exact bit position. Examples are CS rising after the 15th rise, so the write is nearly complete, or extra SCK rises arriving after a complete frame. The bench drives frames with an explicit bit count to reach these cases. Random frames mix in truncated lengths from 1 to 15 and over-long lengths up to 19. Every register is checked against a reference model after each frame, so a commit at the wrong point is caught.

// File: rtl/skew_spi_pkg.sv
package skew_spi_pkg;
  localparam int CODE_W     = 6;
  localparam int NUM_CH     = 3;
  localparam int SEL_W      = 2;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic frameClr;  // frame idle or aborted
    logic shiftEn;   // accepted SCK rise
    logic cmdLoad;   // command byte complete on this rise
    logic commit;    // 16th bit arriving on this rise
  } strobe_t;
endpackage

// File: rtl/skew_spi_ctrl.sv
module skew_spi_ctrl
  import skew_spi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    spiEnable,
  input  logic    csN,
  input  logic    sck,
  output strobe_t strb
);
  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             active;
  logic             sckRise;

  assign active  = spiEnable & ~csN;
  assign sckRise = sck & ~sckPrev;

  always_comb begin
    strb.frameClr = ~active;
    strb.shiftEn  = active & sckRise & (bitCnt != CNT_W'(FRAME_BITS));
    strb.cmdLoad  = strb.shiftEn & (bitCnt == CNT_W'(BYTE_W - 1));
    strb.commit   = strb.shiftEn & (bitCnt == CNT_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sck;
      if (strb.frameClr)     bitCnt <= '0;
      else if (strb.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

  // R7: the counter never passes the frame length
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS));
  // R2: command capture and commit are distinct rises
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cmdLoad, strb.commit}));
  // R6: an idle or aborted frame restarts at bit 0
  assert_abort_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameClr |=> bitCnt == '0);
endmodule

// File: rtl/skew_spi_dpath.sv
module skew_spi_dpath
  import skew_spi_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          sdi,
  output logic                          sdo,
  output logic [NUM_CH-1:0][CODE_W-1:0] codes
);
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] inByte;
  logic [BYTE_W-1:0] sdoReg;
  logic [BYTE_W-1:0] readByte;
  logic              cmdRead;
  logic [SEL_W-1:0]  cmdSel;

  assign inByte = {shiftReg, sdi};
  assign sdo    = sdoReg[BYTE_W-1];

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (inByte[SEL_W-1:0] == SEL_W'(i))
        readByte = {{(BYTE_W-CODE_W){1'b0}}, codes[i]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= '0;
      cmdRead  <= 1'b0;
      cmdSel   <= '0;
    end else if (strb.frameClr) begin
      sdoReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= inByte[BYTE_W-2:0];
      if (strb.cmdLoad) begin
        cmdRead <= inByte[BYTE_W-1];
        cmdSel  <= inByte[SEL_W-1:0];
        sdoReg  <= inByte[BYTE_W-1] ? readByte : '0;
      end else begin
        sdoReg <= {sdoReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_code
    logic wrEn;
    assign wrEn = strb.commit & ~cmdRead & (cmdSel == SEL_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     codes[g] <= '0;
      else if (wrEn) codes[g] <= inByte[CODE_W-1:0];
    end
  end

  // R6: codes move only on a completed frame
  assert_hold_no_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(codes));
  // R5: unmapped select never writes
  assert_no_write_sel3_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && cmdSel == SEL_W'(3)) |=> $stable(codes));
  // R9: idle port keeps SDO low
  assert_idle_sdo_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameClr |=> !sdo);
endmodule

// File: rtl/skew_code_spi.sv
module skew_code_spi
  import skew_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiEnable,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] codeRed,
  output logic [CODE_W-1:0] codeGreen,
  output logic [CODE_W-1:0] codeBlue
);
  strobe_t                       strb;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  skew_spi_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .spiEnable(spiEnable),
    .csN(csN), .sck(sck), .strb(strb)
  );

  skew_spi_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sdi(sdi), .sdo(sdo), .codes(codes)
  );

  assign codeRed   = codes[0];
  assign codeGreen = codes[1];
  assign codeBlue  = codes[2];

  // R8: a disabled port leaves the codes alone
  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !spiEnable |=> $stable({codeRed, codeGreen, codeBlue}));
endmodule

// File: tb/test_skew_code_spi.sv
module test_skew_code_spi;
  logic clk = 1'b0, rstN = 1'b0, spiEnable = 1'b1, csN = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [5:0] codeRed, codeGreen, codeBlue;
  int checks = 0, fails = 0;
  logic [5:0] model [3];

  always #2 clk = ~clk;

  skew_code_spi i_skew_code_spi (
    .clk(clk), .rstN(rstN), .spiEnable(spiEnable), .csN(csN), .sck(sck),
    .sdi(sdi), .sdo(sdo), .codeRed(codeRed), .codeGreen(codeGreen), .codeBlue(codeBlue)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expSdo(logic [15:0] word, bit enabled);
    logic [1:0] sel = word[9:8];
    if (!enabled || !word[15] || sel == 2'd3) return 16'h0;
    return {7'b0, 2'b00, model[sel], 1'b0};
  endfunction

  task automatic runFrame(input logic [15:0] word, input int nBits, output logic [15:0] seen);
    seen = '0;
    csN = 1'b0; tick();
    for (int k = 0; k < nBits; k++) begin
      sdi = (k < 16) ? word[15-k] : 1'b1;
      sck = 1'b0; tick(); tick();
      sck = 1'b1; tick();
      if (k < 16) seen[15-k] = sdo;
    end
    sck = 1'b0; tick();
    csN = 1'b1; tick(); tick();
  endtask

  task automatic applyModel(logic [15:0] word, int nBits);
    if (spiEnable && nBits >= 16 && !word[15] && word[9:8] != 2'd3)
      model[word[9:8]] = word[5:0];
  endtask

  task automatic checkCodes(string req);
    chk(req, {26'b0, codeRed},   {26'b0, model[0]});
    chk(req, {26'b0, codeGreen}, {26'b0, model[1]});
    chk(req, {26'b0, codeBlue},  {26'b0, model[2]});
  endtask

  task automatic frame(string req, logic [15:0] word, int nBits);
    logic [15:0] seen;
    logic [15:0] exp;
    exp = expSdo(word, spiEnable);
    runFrame(word, nBits, seen);
    if (nBits >= 16) chk({req, " sdo"}, {16'b0, seen}, {16'b0, exp});
    applyModel(word, nBits);
    checkCodes(req);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) model[i] = '0;
    tick(); tick(); rstN = 1'b1; tick();
    checkCodes("R1 reset");
    chk("R1 sdo", {31'b0, sdo}, 32'b0);

    frame("R2 green 42", 16'h012A, 16);
    frame("R2 red", 16'h0011, 16);
    frame("R2 blue 21", 16'h0215, 16);
    frame("R4 read blue", 16'h8200, 16);
    frame("R4 read green", 16'h81FF, 16);
    frame("R3 upper bits", 16'h00FF, 16);
    frame("R5 write sel3", 16'h0307, 16);
    frame("R5 read sel3", 16'h8300, 16);
    frame("R6 abort at 15", 16'h0105, 15);
    frame("R6 fresh after abort", 16'h0109, 16);
    frame("R7 extra rises", 16'h0233, 19);
    frame("R9 write sdo", 16'h0001, 16);
    spiEnable = 1'b0;
    frame("R8 disabled write", 16'h0022, 16);
    frame("R8 disabled read", 16'h8100, 16);
    spiEnable = 1'b1;

    for (int n = 0; n < 200; n++) begin
      logic [15:0] w;
      int len;
      w = 16'($urandom());
      w[14:10] = 5'b0;
      case ($urandom_range(0, 9))
        0: len = $urandom_range(1, 15);
        1: len = $urandom_range(17, 19);
        default: len = 16;
      endcase
      frame(len < 16 ? "R6 random" : (w[15] ? "R4 random" : "R2 random"), w, len);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule